// File: doc/BRIEF.md
# Load-Group Executor for an 8-bit Accumulator CPU

This block carries out a small group of data-movement instructions for an 8-bit accumulator processor whose byte registers pair up into 16-bit registers. It takes in a stream of instruction bytes, one byte per cycle in which `fetch_valid` is high. The first byte is an opcode. Some opcodes are followed by operand bytes. Cycles with `fetch_valid` low are idle, so the stream may pause at any point.

It holds four 16-bit register pairs (BC, DE, HL and SP) and puts their current values on output ports. It can fill a pair from a 16-bit immediate, copy HL into SP, or store the accumulator at the address in HL and then step HL up or down. Stores appear on a byte-wide write port with a single-cycle strobe. Each instruction ends with a one-cycle retirement pulse. An opcode outside the group raises a one-cycle illegal pulse instead. None of these instructions touch flags.

Top module: `ldgrp_exec`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `bc`, `de`, `hl` and `sp` read zero, and `mem_we`, `done` and `illegal` are low.
- R2: Opcodes 0x01, 0x11, 0x21 and 0x31 write an immediate into BC, DE, HL and SP respectively (opcode bits 5:4 = 0,1,2,3). Each consumes exactly two further accepted bytes. The new value and `done` appear in the cycle after the second operand byte is accepted.
- R3: The immediate is little-endian. The first operand byte is bits 7:0 and the second is bits 15:8.
- R4: Opcode 0x22, in the cycle after it is accepted, shows `mem_we`=1 for one cycle, `mem_addr` equal to the old HL, `mem_wdata` equal to `acc_val`, and HL equal to the old HL plus one modulo 65536.
- R5: Opcode 0x32 behaves as in R4, except that HL becomes the old HL minus one modulo 65536.
- R6: Opcode 0xF9 takes no operand bytes and issues no write. In the cycle after it is accepted, SP equals HL and `done` is high.
- R7: Any other opcode raises `illegal` for one cycle. It does not raise `done`, issues no write, changes no register, and the next accepted byte is treated as an opcode.
- R8: `done` is high for exactly one cycle per retired instruction and never after a non-final byte. Cycles with `fetch_valid` low change nothing.
- R9: An instruction changes no pair other than the one it names. Stores change only HL, the copy changes only SP, and an immediate load changes only its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Instruction byte present this cycle |
| fetch_byte | input | 8 | Instruction byte (opcode or operand) |
| acc_val | input | 8 | Current accumulator value |
| mem_we | output | 1 | One-cycle byte write strobe |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | Instruction retired (one cycle) |
| illegal | output | 1 | Unsupported opcode seen (one cycle) |
| bc | output | 16 | BC pair |
| de | output | 16 | DE pair |
| hl | output | 16 | HL pair |
| sp | output | 16 | SP pair |

## Verification
The bench builds the block at its default byte width of 8, which makes the pairs and the address 16 bits wide. At that width all 256 opcode values can be swept: every non-group opcode is checked for a quiet illegal pulse, and every group opcode for its exact effect on the four pairs and the write port. The 16-bit size also makes the HL wrap points 0xFFFF and 0x0000 cheap to reach, and they are tested in both step directions. Operand streams with idle gaps are also applied.

// File: rtl/ldgrp_pkg.sv
package ldgrp_pkg;
  typedef enum logic [1:0] {
    ST_OPC,
    ST_LO,
    ST_HI
  } seq_t;

  typedef enum logic [2:0] {
    K_IMM,
    K_STINC,
    K_STDEC,
    K_HL2SP,
    K_BAD
  } kind_t;

  localparam int PAIR_BC = 0;
  localparam int PAIR_DE = 1;
  localparam int PAIR_HL = 2;
  localparam int PAIR_SP = 3;
  localparam int NUM_PAIRS = 4;
endpackage

// File: rtl/ldgrp_decode.sv
module ldgrp_decode
  import ldgrp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opc,
  output kind_t         kind,
  output logic [1:0]    sel
);
  always_comb begin
    sel  = opc[5:4];
    kind = K_BAD;
    if (opc[7:6] == 2'b00 && opc[3:0] == 4'h1) kind = K_IMM;
    else if (opc == DW'(8'h22))                kind = K_STINC;
    else if (opc == DW'(8'h32))                kind = K_STDEC;
    else if (opc == DW'(8'hF9))                kind = K_HL2SP;
  end
endmodule

// File: rtl/ldgrp_pairs.sv
module ldgrp_pairs #(
  parameter  int PW = 16,
  parameter  int NP = 4,
  localparam int SW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] rd [NP]
);
  logic [PW-1:0] q [NP];

  for (genvar g = 0; g < NP; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst)                                q[g] <= '0;
      else if (wr_en && wr_sel == SW'(g))     q[g] <= wr_data;
    end
    assign rd[g] = q[g];

    // R9: a pair not addressed by the write port keeps its value
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_sel == SW'(g)) |=> $stable(q[g]));
  end
endmodule

// File: rtl/ldgrp_exec.sv
module ldgrp_exec
  import ldgrp_pkg::*;
#(
  parameter  int DW = 8,
  localparam int PW = 2 * DW,
  localparam int SW = $clog2(NUM_PAIRS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_byte,
  input  logic [DW-1:0] acc_val,
  output logic          mem_we,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done,
  output logic          illegal,
  output logic [PW-1:0] bc,
  output logic [PW-1:0] de,
  output logic [PW-1:0] hl,
  output logic [PW-1:0] sp
);
  seq_t          seq_q;
  logic [SW-1:0] tgt_q;
  logic [DW-1:0] lo_q;
  kind_t         kind;
  logic [1:0]    dsel;
  logic          wr_en;
  logic [SW-1:0] wr_sel;
  logic [PW-1:0] wr_data;
  logic [PW-1:0] rd [NUM_PAIRS];

  ldgrp_decode #(.DW(DW)) dec_i (
    .opc  (fetch_byte),
    .kind (kind),
    .sel  (dsel)
  );

  ldgrp_pairs #(.PW(PW), .NP(NUM_PAIRS)) pairs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd      (rd)
  );

  assign bc = rd[PAIR_BC];
  assign de = rd[PAIR_DE];
  assign hl = rd[PAIR_HL];
  assign sp = rd[PAIR_SP];

  always_comb begin
    wr_en   = 1'b0;
    wr_sel  = SW'(PAIR_HL);
    wr_data = hl;
    if (fetch_valid) begin
      if (seq_q == ST_OPC) begin
        unique case (kind)
          K_STINC: begin wr_en = 1'b1; wr_data = hl + PW'(1); end
          K_STDEC: begin wr_en = 1'b1; wr_data = hl - PW'(1); end
          K_HL2SP: begin wr_en = 1'b1; wr_sel = SW'(PAIR_SP); end
          default: ;
        endcase
      end else if (seq_q == ST_HI) begin
        wr_en   = 1'b1;
        wr_sel  = tgt_q;
        wr_data = {fetch_byte, lo_q};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q     <= ST_OPC;
      tgt_q     <= '0;
      lo_q      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      if (fetch_valid) begin
        unique case (seq_q)
          ST_OPC: begin
            unique case (kind)
              K_IMM: begin
                seq_q <= ST_LO;
                tgt_q <= SW'(dsel);
              end
              K_STINC, K_STDEC: begin
                mem_we    <= 1'b1;
                mem_addr  <= hl;
                mem_wdata <= acc_val;
                done      <= 1'b1;
              end
              K_HL2SP: done    <= 1'b1;
              default: illegal <= 1'b1;
            endcase
          end
          ST_LO: begin
            lo_q  <= fetch_byte;
            seq_q <= ST_HI;
          end
          default: begin
            seq_q <= ST_OPC;
            done  <= 1'b1;
          end
        endcase
      end
    end
  end

  // R4/R5: a store leaves HL one step away from the address it wrote
  p_store_step_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (hl == mem_addr + PW'(1)) || (hl == mem_addr - PW'(1)));

  // R7: illegal and done never coincide, and illegal issues no write
  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !done && !mem_we);

  // R6: an accepted copy opcode leaves SP equal to the previous HL
  p_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && seq_q == ST_OPC && kind == K_HL2SP) |=> sp == $past(hl));

  // R8: a write strobe always comes with retirement
  p_write_retires_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> done);

  // R8: no retirement while an operand is still owed
  p_no_early_done_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_q != ST_OPC) |-> !done);
endmodule

// File: tb/ldgrp_exec_tb_top.sv
module ldgrp_exec_tb_top;
  localparam int DW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetch_valid = 1'b0;
  logic [DW-1:0] fetch_byte = '0;
  logic [DW-1:0] acc_val = '0;
  logic          mem_we, done, illegal;
  logic [PW-1:0] mem_addr, bc, de, hl, sp;
  logic [DW-1:0] mem_wdata;

  int vec = 0;
  int bad = 0;
  logic [PW-1:0] m [4];

  always #10 clk = ~clk;

  ldgrp_exec #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .acc_val(acc_val), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .illegal(illegal), .bc(bc), .de(de), .hl(hl), .sp(sp)
  );

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    chk({req, " bc"}, bc, m[0]);
    chk({req, " de"}, de, m[1]);
    chk({req, " hl"}, hl, m[2]);
    chk({req, " sp"}, sp, m[3]);
  endtask

  // drive one byte for one edge; return at the following falling edge
  task automatic put(logic [7:0] b);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_byte  = b;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic load_imm(logic [7:0] op, logic [7:0] lo, logic [7:0] hi, int gap);
    put(op);
    chk("R8 no done after opcode", PW'(done), 0);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk("R8 idle gap no done", PW'(done), 0);
    end
    put(lo);
    chk("R8 no done after low byte", PW'(done), 0);
    chk_regs("R9 regs unchanged mid-load");
    put(hi);
    m[op[5:4]] = {hi, lo};
    chk("R2 done after high byte", PW'(done), 1);
    chk("R3 little-endian value", m[op[5:4]], {hi, lo});
    chk_regs("R2/R9 regs after load");
  endtask

  task automatic store(logic [7:0] op, logic [7:0] a);
    logic [PW-1:0] old;
    old = m[2];
    acc_val = a;
    put(op);
    m[2] = (op == 8'h22) ? old + 16'd1 : old - 16'd1;
    chk("R4 write strobe", PW'(mem_we), 1);
    chk("R4 write address", mem_addr, old);
    chk("R4 write data", PW'(mem_wdata), PW'(a));
    chk("R4 done", PW'(done), 1);
    chk_regs(op == 8'h22 ? "R4 hl increment" : "R5 hl decrement");
    @(negedge clk);
    chk("R8 strobe one cycle", PW'(mem_we), 0);
    chk("R8 done one cycle", PW'(done), 0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++;
      vec++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    chk_regs("R1 reset regs");
    chk("R1 reset strobe", PW'(mem_we), 0);
    chk("R1 reset done", PW'(done), 0);
    chk("R1 reset illegal", PW'(illegal), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_regs("R1 regs after release");
    chk("R1 done after release", PW'(done), 0);

    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      if (o == 8'h01 || o == 8'h11 || o == 8'h21 || o == 8'h31) begin
        load_imm(o, o ^ 8'h5A, ~o, op % 3);
      end else if (o == 8'h22 || o == 8'h32) begin
        store(o, o ^ 8'hC3);
      end else if (o == 8'hF9) begin
        put(o);
        m[3] = m[2];
        chk("R6 done", PW'(done), 1);
        chk("R6 no write", PW'(mem_we), 0);
        chk_regs("R6 sp from hl");
      end else begin
        put(o);
        chk("R7 illegal pulse", PW'(illegal), 1);
        chk("R7 no done", PW'(done), 0);
        chk("R7 no write", PW'(mem_we), 0);
        chk_regs("R7 regs unchanged");
        @(negedge clk);
        chk("R7 illegal one cycle", PW'(illegal), 0);
      end
    end

    // HL wrap in both directions
    load_imm(8'h21, 8'hFF, 8'hFF, 0);
    store(8'h22, 8'h11);
    chk("R4 wrap to zero", hl, 16'h0000);
    store(8'h32, 8'h22);
    chk("R5 wrap to ffff", hl, 16'hFFFF);
    store(8'h32, 8'h33);
    chk("R5 decrement from ffff", hl, 16'hFFFE);

    // each pair with distinct patterns, then copy
    for (int k = 0; k < 16; k++) begin
      load_imm(8'h01 + 8'(16 * (k % 4)), 8'(k * 17), 8'(255 - k * 13), k % 2);
    end
    put(8'hF9);
    m[3] = m[2];
    chk_regs("R6 copy after sweep");
    chk("R6 sp equals hl", sp, hl);

    // illegal between opcode streams; next byte is an opcode again
    put(8'hFF);
    chk("R7 illegal 0xFF", PW'(illegal), 1);
    load_imm(8'h11, 8'h34, 8'h12, 0);
    chk("R3 de reads 1234", de, 16'h1234);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule